// File: doc/BRIEF.md
# Dual-lane serial I/Q transmitter

This block sits on the baseband side of a serial sample link. It takes one I word and one Q word per handshake and shifts them out at the same time on two single-bit lanes, most significant bit first. Each frame carries 16 or 12 bits per lane, chosen when the sample is accepted. A framing strobe marks the first bit of every frame. The strobe is either a pulse one tick wide or a level that stays high for the first half of the frame. The block also drives the bit clock for the receiver.

The block runs on a clock at twice the bit rate, so one bit period is two ticks. The forwarded bit clock `sclk_o` toggles on every tick. It is low in the first tick of each bit and high in the second, so the receiver can sample on its rising edge. Samples arrive on a valid/ready stream. `s_ready_o` depends only on internal state, never on `s_valid_i`. A producer that raises valid must hold the data and settings stable until a cycle in which ready is also high; that cycle is the transfer. Ready rises only in the last tick of a frame, or in the high-clock tick while idle. A producer that keeps valid asserted therefore gets frames with no gap between them. When no sample is pending, both lanes and the strobe rest low.

Top module: `iq_lane_serializer`

## Requirements
- R1: The I and Q words are sent simultaneously, one bit per lane per bit period, most significant bit first. Each bit is held unchanged for both ticks of its period.
- R2: With `long_word_i`=1 at acceptance, a frame carries all 16 bits of each input word, in 32 ticks.
- R3: With `long_word_i`=0 at acceptance, a frame carries input bits [15:4] of each word, in 24 ticks. Bits [3:0] have no effect on the lanes.
- R4: With `level_strobe_i`=0 at acceptance, `strobe_o` is high only in the first tick of the frame.
- R5: With `level_strobe_i`=1 at acceptance, `strobe_o` is high for the first half of the frame: 8 bit periods (16 ticks) for a 16-bit frame, 6 bit periods (12 ticks) for a 12-bit frame. It is low for the rest of the frame.
- R6: `sclk_o` toggles on every tick. It is low in the first tick of each bit period, and a frame always starts in a tick with `sclk_o` low.
- R7: `s_ready_o` is high only in a tick with `sclk_o` high, and then only while idle or during the last bit of a frame. A transfer makes the new frame start on the very next tick.
- R8: While valid samples keep arriving, frames follow each other with no idle tick between them.
- R9: When no frame is in progress, `lane_i_o`, `lane_q_o` and `strobe_o` are low.
- R10: `long_word_i` and `level_strobe_i` are taken only in the transfer cycle. Changing them at any other time does not alter the frame in progress.
- R11: While `rst_i` is high, all outputs are low. After the first clock edge with reset low, `sclk_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Internal clock, twice the bit rate |
| rst_i | input | 1 | Synchronous reset, active high |
| s_valid_i | input | 1 | Sample pair offered |
| s_ready_o | output | 1 | Sample pair taken when valid is also high |
| s_i_data_i | input | 16 | I word |
| s_q_data_i | input | 16 | Q word |
| long_word_i | input | 1 | 1 = 16-bit frame, 0 = 12-bit frame |
| level_strobe_i | input | 1 | 1 = half-frame level strobe, 0 = one-tick pulse |
| sclk_o | output | 1 | Forwarded bit clock |
| lane_i_o | output | 1 | Serial I lane |
| lane_q_o | output | 1 | Serial Q lane |
| strobe_o | output | 1 | Frame strobe |

## Verification
The hardest case to reach is the frame boundary where a transfer overlaps the last bit of the previous frame. At that instant the width and strobe settings change, the shift registers reload and the strobe must restart, all in one tick. The bench reaches this case by keeping valid high through a whole sequence, with the width and strobe settings of the next frame differing from those of the frame being sent. It also drives random settings while valid is low, both in idle gaps and mid-frame. A tick-level model checks every tick of every frame against the lanes, strobe, clock and ready.

// File: rtl/iqser_pkg.sv
package iqser_pkg;
  localparam int unsigned WORD_W     = 16;
  localparam int unsigned SHORT_BITS = 12;
  localparam int unsigned CNT_W      = $clog2(WORD_W);

  typedef enum logic {
    SHAPE_PULSE = 1'b0,
    SHAPE_LEVEL = 1'b1
  } strobe_shape_e;
endpackage

// File: rtl/iqser_timer.sv
module iqser_timer
  import iqser_pkg::*;
#(
  parameter int unsigned LONG_N  = WORD_W,
  parameter int unsigned SHORT_N = SHORT_BITS,
  parameter int unsigned CW      = CNT_W
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          valid_i,
  input  logic          long_i,
  input  logic          level_i,
  output logic          ph_o,
  output logic          busy_o,
  output logic [CW-1:0] bit_idx_o,
  output logic          ready_o,
  output logic          load_o,
  output logic          shift_o,
  output logic          cur_long_o,
  output strobe_shape_e cur_shape_o
);
  localparam logic [CW-1:0] LAST_LONG  = CW'(LONG_N - 1);
  localparam logic [CW-1:0] LAST_SHORT = CW'(SHORT_N - 1);

  logic          ph_q, busy_q, long_q;
  logic [CW-1:0] idx_q;
  strobe_shape_e shape_q;
  logic          last_bit;

  assign last_bit = busy_q && (idx_q == (long_q ? LAST_LONG : LAST_SHORT));
  assign ready_o  = ph_q && (!busy_q || last_bit);
  assign load_o   = ready_o && valid_i;
  assign shift_o  = busy_q && ph_q && !last_bit;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ph_q    <= 1'b0;
      busy_q  <= 1'b0;
      idx_q   <= '0;
      long_q  <= 1'b1;
      shape_q <= SHAPE_PULSE;
    end else begin
      ph_q <= ~ph_q;
      if (load_o) begin
        busy_q  <= 1'b1;
        idx_q   <= '0;
        long_q  <= long_i;
        shape_q <= strobe_shape_e'(level_i);
      end else if (busy_q && ph_q) begin
        if (last_bit) busy_q <= 1'b0;
        else          idx_q  <= idx_q + 1'b1;
      end
    end
  end

  assign ph_o        = ph_q;
  assign busy_o      = busy_q;
  assign bit_idx_o   = idx_q;
  assign cur_long_o  = long_q;
  assign cur_shape_o = shape_q;
endmodule

// File: rtl/iqser_lane.sv
module iqser_lane #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic         busy_i,
  input  logic [W-1:0] word_i,
  output logic         bit_o
);
  logic [W-1:0] sh_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)        sh_q <= '0;
    else if (load_i)  sh_q <= word_i;
    else if (shift_i) sh_q <= {sh_q[W-2:0], 1'b0};
  end

  assign bit_o = busy_i & sh_q[W-1];
endmodule

// File: rtl/iqser_strobe.sv
module iqser_strobe
  import iqser_pkg::*;
#(
  parameter int unsigned LONG_N  = WORD_W,
  parameter int unsigned SHORT_N = SHORT_BITS,
  parameter int unsigned CW      = CNT_W
) (
  input  logic          busy_i,
  input  logic          ph_i,
  input  logic [CW-1:0] bit_idx_i,
  input  logic          long_i,
  input  strobe_shape_e shape_i,
  output logic          strobe_o
);
  localparam logic [CW-1:0] HALF_LONG  = CW'(LONG_N / 2);
  localparam logic [CW-1:0] HALF_SHORT = CW'(SHORT_N / 2);

  logic [CW-1:0] half;
  logic          level_hi, pulse_hi;

  always_comb begin
    half     = long_i ? HALF_LONG : HALF_SHORT;
    level_hi = bit_idx_i < half;
    pulse_hi = (bit_idx_i == '0) && !ph_i;
    strobe_o = busy_i && ((shape_i == SHAPE_LEVEL) ? level_hi : pulse_hi);
  end
endmodule

// File: rtl/iq_lane_serializer.sv
module iq_lane_serializer
  import iqser_pkg::*;
#(
  parameter int unsigned DATA_W  = WORD_W,
  parameter int unsigned SHORT_N = SHORT_BITS
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              s_valid_i,
  output logic              s_ready_o,
  input  logic [DATA_W-1:0] s_i_data_i,
  input  logic [DATA_W-1:0] s_q_data_i,
  input  logic              long_word_i,
  input  logic              level_strobe_i,
  output logic              sclk_o,
  output logic              lane_i_o,
  output logic              lane_q_o,
  output logic              strobe_o
);
  localparam int unsigned CW    = $clog2(DATA_W);
  localparam int unsigned LANES = 2;

  logic          ph, busy, load, shift, cur_long;
  logic [CW-1:0] bit_idx;
  strobe_shape_e cur_shape;
  logic [DATA_W-1:0] words [LANES];
  logic [LANES-1:0]  bits;

  iqser_timer #(.LONG_N(DATA_W), .SHORT_N(SHORT_N), .CW(CW)) u_timer (
    .clk_i(clk_i), .rst_i(rst_i), .valid_i(s_valid_i),
    .long_i(long_word_i), .level_i(level_strobe_i),
    .ph_o(ph), .busy_o(busy), .bit_idx_o(bit_idx), .ready_o(s_ready_o),
    .load_o(load), .shift_o(shift), .cur_long_o(cur_long),
    .cur_shape_o(cur_shape)
  );

  assign words[0] = s_i_data_i;
  assign words[1] = s_q_data_i;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    iqser_lane #(.W(DATA_W)) u_lane (
      .clk_i(clk_i), .rst_i(rst_i), .load_i(load), .shift_i(shift),
      .busy_i(busy), .word_i(words[g]), .bit_o(bits[g])
    );
  end

  iqser_strobe #(.LONG_N(DATA_W), .SHORT_N(SHORT_N), .CW(CW)) u_strobe (
    .busy_i(busy), .ph_i(ph), .bit_idx_i(bit_idx), .long_i(cur_long),
    .shape_i(cur_shape), .strobe_o(strobe_o)
  );

  assign sclk_o   = ph;
  assign lane_i_o = bits[0];
  assign lane_q_o = bits[1];
endmodule

// File: rtl/iqser_checker.sv
module iqser_checker (
  input logic clk_i,
  input logic rst_i,
  input logic s_valid_i,
  input logic s_ready_o,
  input logic level_strobe_i,
  input logic sclk_o,
  input logic lane_i_o,
  input logic lane_q_o,
  input logic strobe_o
);
  assert_clk_rise_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    !sclk_o |=> sclk_o);
  assert_clk_fall_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    sclk_o |=> !sclk_o);
  assert_ready_phase_R7: assert property (@(posedge clk_i) disable iff (rst_i)
    s_ready_o |-> sclk_o);
  assert_bit_hold_R1: assert property (@(posedge clk_i) disable iff (rst_i)
    !sclk_o |=> ($stable(lane_i_o) && $stable(lane_q_o)));
  assert_pulse_start_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    (s_valid_i && s_ready_o && !level_strobe_i) |=> (strobe_o && !sclk_o));
  assert_strobe_align_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(strobe_o) |-> !sclk_o);
endmodule

bind iq_lane_serializer iqser_checker u_iqser_checker (
  .clk_i(clk_i), .rst_i(rst_i), .s_valid_i(s_valid_i), .s_ready_o(s_ready_o),
  .level_strobe_i(level_strobe_i), .sclk_o(sclk_o), .lane_i_o(lane_i_o),
  .lane_q_o(lane_q_o), .strobe_o(strobe_o)
);

// File: tb/test_iq_lane_serializer.sv
module test_iq_lane_serializer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid = 1'b0;
  logic [15:0] di = '0, dq = '0;
  logic        long_w = 1'b1, level = 1'b0;
  logic        ready, sclk, li, lq, stb;

  int checks = 0;
  int errors = 0;

  logic [15:0] fi [8];
  logic [15:0] fq [8];
  bit          fw [8];
  bit          fm [8];

  always #2 clk = ~clk;

  iq_lane_serializer i_iq_lane_serializer (
    .clk_i(clk), .rst_i(rst), .s_valid_i(valid), .s_ready_o(ready),
    .s_i_data_i(di), .s_q_data_i(dq), .long_word_i(long_w),
    .level_strobe_i(level), .sclk_o(sclk), .lane_i_o(li), .lane_q_o(lq),
    .strobe_o(stb)
  );

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  // Tick-level model: sends frames 0..n-1, with 'gap' idle negedges after each transfer.
  task automatic run_stream(int n, int gap, string tag);
    int k = 0, t = 0, gc = 0, idle = 0, guard = 0;
    bit act = 0, cl = 0, cm = 0;
    logic [15:0] ci = '0, cq = '0;
    while (k < n || act || idle < 4) begin
      @(negedge clk);
      guard++;
      if (guard > 3000) begin
        errors++;
        $display("FAIL %s stream stalled", tag);
        break;
      end
      if (act) begin
        int len = cl ? 16 : 12;
        int b = t / 2;
        bit eb;
        chk(tag, "lane I", {15'd0, li}, {15'd0, ci[15-b]});
        chk(tag, "lane Q", {15'd0, lq}, {15'd0, cq[15-b]});
        eb = cm ? (b < len / 2) : (t == 0);
        chk(cm ? "R5" : "R4", "strobe", {15'd0, stb}, {15'd0, eb});
        chk("R6", "sclk", {15'd0, sclk}, {15'd0, t[0]});
        chk("R7", "ready", {15'd0, ready}, {15'd0, sclk && (t == 2 * len - 1)});
      end else begin
        chk("R9", "idle lanes+strobe", {13'd0, li, lq, stb}, 16'd0);
        chk("R7", "idle ready", {15'd0, ready}, {15'd0, sclk});
      end
      if (k < n && gc == 0) begin
        valid = 1'b1; di = fi[k]; dq = fq[k]; long_w = fw[k]; level = fm[k];
      end else begin
        valid = 1'b0; di = 16'($urandom); dq = 16'($urandom);
        long_w = 1'($urandom); level = 1'($urandom);
        if (gc > 0) gc--;
      end
      if (act) begin
        t++;
        if (t == 2 * (cl ? 16 : 12)) act = 0;
      end
      if (valid && ready) begin
        act = 1; t = 0; ci = fi[k]; cq = fq[k]; cl = fw[k]; cm = fm[k];
        k++; gc = gap;
      end
      if (k >= n && !act) idle++;
    end
    valid = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11", "outputs in reset", {11'd0, ready, sclk, li, lq, stb}, 16'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R11", "sclk after reset", {15'd0, sclk}, 16'd1);
  endtask

  task automatic t_pulse16();
    fi[0] = 16'hA5C3; fq[0] = 16'h5A3C; fw[0] = 1; fm[0] = 0;
    fi[1] = 16'h8001; fq[1] = 16'hFFFE; fw[1] = 1; fm[1] = 0;
    run_stream(2, 3, "R2");
  endtask

  task automatic t_level16();
    fi[0] = 16'h1234; fq[0] = 16'hFEDC; fw[0] = 1; fm[0] = 1;
    fi[1] = 16'hFFFF; fq[1] = 16'h0000; fw[1] = 1; fm[1] = 1;
    run_stream(2, 5, "R1");
  endtask

  task automatic t_short12();
    fi[0] = 16'hABCF; fq[0] = 16'h000F; fw[0] = 0; fm[0] = 0;
    fi[1] = 16'h700A; fq[1] = 16'hC005; fw[1] = 0; fm[1] = 1;
    run_stream(2, 2, "R3");
  endtask

  task automatic t_back_to_back();
    fi[0] = 16'hF00F; fq[0] = 16'h0FF0; fw[0] = 1; fm[0] = 0;
    fi[1] = 16'h3C3F; fq[1] = 16'hC3C7; fw[1] = 0; fm[1] = 1;
    fi[2] = 16'h9999; fq[2] = 16'h6666; fw[2] = 1; fm[2] = 1;
    fi[3] = 16'h5551; fq[3] = 16'hAAA2; fw[3] = 0; fm[3] = 0;
    fi[4] = 16'h0001; fq[4] = 16'h8000; fw[4] = 1; fm[4] = 0;
    run_stream(5, 0, "R8");
  endtask

  task automatic t_settings_mid_frame();
    fi[0] = 16'hCAFE; fq[0] = 16'hBEEF; fw[0] = 0; fm[0] = 1;
    fi[1] = 16'hDEAD; fq[1] = 16'hF00D; fw[1] = 1; fm[1] = 0;
    fi[2] = 16'h1357; fq[2] = 16'h2468; fw[2] = 0; fm[2] = 0;
    run_stream(3, 7, "R10");
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_pulse16();
        t_level16();
        t_short12();
        t_back_to_back();
        t_settings_mid_frame();
      end
      begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule